// File: doc/BRIEF.md
# Interleaved Multi-Context Issue Scheduler

This block is the context-selection front end of a barrel-style pipeline that carries many logical processors on one physical pipeline. It keeps a program counter and a ready/parked status for each context. Every cycle it offers one ready context and that context's PC on an issue port. Because the pipeline has neither stall logic nor forwarding, the scheduler moves to a different context on every accepted issue, so two consecutive issues never come from the same context unless only one context is ready.

A context that meets a long-latency event is parked through the block port and skipped until it is woken. The event is either a cache miss or an instruction that the pipeline does not implement, which is handed to an external software host. A cache-miss wake releases a context parked on a miss. A context parked on the software host carries a separate pending flag, and only a host-return wake releases it. That wake also writes the PC the host computed. The pipeline writes back the next PC of each issued context on the update port.

The issue port is valid/ready. `iss_valid` is high whenever any context is ready. An issue is accepted in a cycle where `iss_valid` and `iss_ready` are both high. When `iss_ready` is low the offer is held: the same context and PC stay on the port and the rotation does not move. The update, block and wake ports are plain single-cycle strobes. Every state change they cause is visible from the next cycle.

Top module: `ctx_sched`

## Requirements
- R1: After reset every context is ready and none is host-pending. All PCs hold RESET_PC, and the first offer is context 0 with PC RESET_PC.
- R2: The offered context is the first ready context after the last accepted context, in increasing ID order with wrap-around from NUM_CTX-1 to 0.
- R3: Two consecutive accepted issues name the same context only when exactly one context is ready.
- R4: With no context ready, `iss_valid` is low. The rotation pointer moves only on an accepted issue, so with `iss_ready` low the same context stays offered.
- R5: `upd_en` writes `upd_pc` into the PC of `upd_ctx`. The new PC is offered from the next cycle on.
- R6: `blk_en` clears the ready bit of `blk_ctx` from the next cycle. With `blk_host`=1 it also sets the context's host-pending flag, and a block with `blk_host`=0 leaves the pending flag as it was. `rdy_mask` and `host_mask` show the ready bits and pending flags, with bit i for context i.
- R7: A wake with `wake_host`=0 (miss return) sets the context ready if it is not host-pending. It has no effect on a host-pending context.
- R8: A wake with `wake_host`=1 (host return) on a host-pending context clears the pending flag, sets the context ready and writes `wake_pc` as its PC. On a context that is not host-pending it has no effect on status or PC.
- R9: When a block and a wake name the same context in the same cycle, the block is discarded and only the wake is applied.
- R10: When an accepted host return and `upd_en` name the same context in the same cycle, `wake_pc` is stored. Updates to different contexts in that cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | output | 1 | A ready context is being offered |
| iss_ready | input | 1 | Pipeline accepts the offer this cycle |
| iss_ctx | output | CTX_W | Offered context ID |
| iss_pc | output | PC_W | PC of the offered context |
| upd_en | input | 1 | Write next PC |
| upd_ctx | input | CTX_W | Context for the PC write |
| upd_pc | input | PC_W | Next PC value |
| blk_en | input | 1 | Park a context |
| blk_ctx | input | CTX_W | Context to park |
| blk_host | input | 1 | 1: handed to software host, 0: cache miss |
| wake_en | input | 1 | Wake a context |
| wake_ctx | input | CTX_W | Context to wake |
| wake_host | input | 1 | 1: host return, 0: miss return |
| wake_pc | input | PC_W | PC from the host, used when wake_host=1 |
| rdy_mask | output | NUM_CTX | Ready bit per context |
| host_mask | output | NUM_CTX | Host-pending flag per context |

## Verification
The bench parks every context so that the offer must drop. It then leaves a single context ready, to test the one case where the same context may issue back to back. A scheduler that let the same context issue twice with others ready would break R3. One that kept `iss_valid` high with nothing ready would issue a parked context. Holding `iss_ready` low checks that the pointer stays put: a design that advanced on the offer instead of on acceptance would skip contexts. Miss wakes are sent to host-pending contexts and host returns to non-pending ones, which catches a design that releases a context early or corrupts its PC. Block/wake collisions and update/host-return collisions on the same context check the priority rules. A long pseudo-random phase is compared cycle by cycle against a behavioural model.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;
  typedef enum logic {
    PARK_MISS = 1'b0,
    PARK_HOST = 1'b1
  } park_cause_e;
endpackage

// File: rtl/ctx_pc_store.sv
module ctx_pc_store #(
  parameter int N = 16,
  parameter int W = 4,
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wa_en,
  input  logic [W-1:0]    wa_idx,
  input  logic [PC_W-1:0] wa_val,
  input  logic            wb_en,
  input  logic [W-1:0]    wb_idx,
  input  logic [PC_W-1:0] wb_val,
  input  logic [W-1:0]    rd_idx,
  output logic [PC_W-1:0] rd_val
);
  logic [PC_W-1:0] pcs [N];

  // Port b (host return) overrides port a on the same entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) pcs[i] <= RESET_PC;
    end else begin
      if (wa_en && !(wb_en && wb_idx == wa_idx)) pcs[wa_idx] <= wa_val;
      if (wb_en) pcs[wb_idx] <= wb_val;
    end
  end

  assign rd_val = pcs[rd_idx];
endmodule

// File: rtl/ctx_status.sv
module ctx_status #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         blk_en,
  input  logic [W-1:0] blk_ctx,
  input  logic         blk_host,
  input  logic         wake_en,
  input  logic [W-1:0] wake_ctx,
  input  logic         wake_host,
  output logic [N-1:0] rdy,
  output logic [N-1:0] pend,
  output logic         ret_take
);
  import ctx_sched_pkg::*;

  assign ret_take = wake_en && (wake_host == PARK_HOST) && pend[wake_ctx];

  for (genvar i = 0; i < N; i++) begin : g_ctx
    logic hit_wake, hit_blk;
    assign hit_wake = wake_en && wake_ctx == W'(i);
    assign hit_blk  = blk_en && blk_ctx == W'(i) && !hit_wake;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy[i]  <= 1'b1;
        pend[i] <= 1'b0;
      end else if (hit_wake) begin
        if (wake_host == PARK_HOST) begin
          if (pend[i]) begin
            pend[i] <= 1'b0;
            rdy[i]  <= 1'b1;
          end
        end else if (!pend[i]) begin
          rdy[i] <= 1'b1;
        end
      end else if (hit_blk) begin
        rdy[i] <= 1'b0;
        if (blk_host == PARK_HOST) pend[i] <= 1'b1;
      end
    end

    assert_pending_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pend[i] |-> !rdy[i]);

    assert_miss_wake_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_wake && wake_host == PARK_MISS && pend[i]) |=> (pend[i] && !rdy[i]));

    assert_wake_beats_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_en && blk_ctx == W'(i) && hit_wake && wake_host == PARK_MISS && !pend[i]) |=> rdy[i]);
  end
endmodule

// File: rtl/ctx_rr_pick.sv
module ctx_rr_pick #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] last,
  output logic         any,
  output logic [W-1:0] pick
);
  always_comb begin
    logic found;
    int   idx;
    found = 1'b0;
    pick  = '0;
    for (int off = 1; off <= N; off++) begin
      idx = (int'(last) + off) % N;
      if (!found && req[idx]) begin
        pick  = W'(idx);
        found = 1'b1;
      end
    end
    any = |req;
  end
endmodule

// File: rtl/ctx_sched.sv
module ctx_sched #(
  parameter int NUM_CTX = 16,
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = 32'h0000_1000,
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               iss_valid,
  input  logic               iss_ready,
  output logic [CTX_W-1:0]   iss_ctx,
  output logic [PC_W-1:0]    iss_pc,
  input  logic               upd_en,
  input  logic [CTX_W-1:0]   upd_ctx,
  input  logic [PC_W-1:0]    upd_pc,
  input  logic               blk_en,
  input  logic [CTX_W-1:0]   blk_ctx,
  input  logic               blk_host,
  input  logic               wake_en,
  input  logic [CTX_W-1:0]   wake_ctx,
  input  logic               wake_host,
  input  logic [PC_W-1:0]    wake_pc,
  output logic [NUM_CTX-1:0] rdy_mask,
  output logic [NUM_CTX-1:0] host_mask
);
  logic [CTX_W-1:0] last_q;
  logic             ret_take;
  logic             fire;

  ctx_status #(.N(NUM_CTX), .W(CTX_W)) u_status (
    .clk(clk), .rst_n(rst_n),
    .blk_en(blk_en), .blk_ctx(blk_ctx), .blk_host(blk_host),
    .wake_en(wake_en), .wake_ctx(wake_ctx), .wake_host(wake_host),
    .rdy(rdy_mask), .pend(host_mask), .ret_take(ret_take)
  );

  ctx_rr_pick #(.N(NUM_CTX), .W(CTX_W)) u_pick (
    .req(rdy_mask), .last(last_q), .any(iss_valid), .pick(iss_ctx)
  );

  ctx_pc_store #(.N(NUM_CTX), .W(CTX_W), .PC_W(PC_W), .RESET_PC(RESET_PC)) u_pcs (
    .clk(clk), .rst_n(rst_n),
    .wa_en(upd_en), .wa_idx(upd_ctx), .wa_val(upd_pc),
    .wb_en(ret_take), .wb_idx(wake_ctx), .wb_val(wake_pc),
    .rd_idx(iss_ctx), .rd_val(iss_pc)
  );

  assign fire = iss_valid && iss_ready;

  // Reset pointer sits on the last ID so context 0 is offered first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= CTX_W'(NUM_CTX - 1);
    else if (fire) last_q <= iss_ctx;
  end

  assert_offer_is_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> rdy_mask[iss_ctx]);

  assert_no_repeat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!(fire && iss_ctx == $past(iss_ctx)) || $countones(rdy_mask) == 1));

  assert_idle_when_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_mask == '0) |-> !iss_valid);

  assert_hold_offer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !blk_en && !wake_en) |=> (iss_valid && $stable(iss_ctx)));
endmodule

// File: tb/ctx_sched_test.sv
module ctx_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int W = 4;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid, iss_ready;
  logic [W-1:0] iss_ctx;
  logic [31:0] iss_pc;
  logic upd_en, blk_en, blk_host, wake_en, wake_host;
  logic [W-1:0] upd_ctx, blk_ctx, wake_ctx;
  logic [31:0] upd_pc, wake_pc;
  logic [N-1:0] rdy_mask, host_mask;

  ctx_sched #(.NUM_CTX(N), .PC_W(32), .RESET_PC(RST_PC)) uut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_ctx(iss_ctx), .iss_pc(iss_pc),
    .upd_en(upd_en), .upd_ctx(upd_ctx), .upd_pc(upd_pc),
    .blk_en(blk_en), .blk_ctx(blk_ctx), .blk_host(blk_host),
    .wake_en(wake_en), .wake_ctx(wake_ctx), .wake_host(wake_host), .wake_pc(wake_pc),
    .rdy_mask(rdy_mask), .host_mask(host_mask)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // Behavioural reference state
  bit m_rdy [N];
  bit m_pend[N];
  logic [31:0] m_pc[N];
  int m_last;
  bit prev_fire;
  int prev_ctx;

  function automatic int m_pick();
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = (m_last + off) % N;
      if (m_rdy[idx]) return idx;
    end
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_rdy[i] = 1; m_pend[i] = 0; m_pc[i] = RST_PC; end
      m_last = N - 1;
      prev_fire = 0;
      prev_ctx = -1;
    end else begin
      int p;
      bit took;
      p = m_pick();
      prev_fire = (p >= 0) && iss_ready;
      prev_ctx = p;
      if (prev_fire) m_last = p;
      took = 0;
      if (upd_en) m_pc[upd_ctx] = upd_pc;
      if (wake_en) begin
        if (wake_host) begin
          if (m_pend[wake_ctx]) begin
            m_pend[wake_ctx] = 0; m_rdy[wake_ctx] = 1; m_pc[wake_ctx] = wake_pc; took = 1;
          end
        end else if (!m_pend[wake_ctx]) m_rdy[wake_ctx] = 1;
      end
      if (blk_en && !(wake_en && wake_ctx == blk_ctx)) begin
        m_rdy[blk_ctx] = 0;
        if (blk_host) m_pend[blk_ctx] = 1;
      end
      if (took) begin end
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    int p;
    logic [N-1:0] er, ep;
    p = m_pick();
    chk(tag, "iss_valid", 64'(iss_valid), 64'(p >= 0));
    if (p >= 0) begin
      chk(tag, "iss_ctx", 64'(iss_ctx), 64'(p));
      chk(tag, "iss_pc", 64'(iss_pc), 64'(m_pc[p]));
    end
    for (int i = 0; i < N; i++) begin er[i] = m_rdy[i]; ep[i] = m_pend[i]; end
    chk(tag, "rdy_mask", 64'(rdy_mask), 64'(er));
    chk(tag, "host_mask", 64'(host_mask), 64'(ep));
    // R3: back-to-back issue of one context only when it is the sole ready one
    if (prev_fire && iss_valid && 32'(iss_ctx) == prev_ctx)
      chk("R3", "single ready on repeat", 64'($countones(rdy_mask)), 64'd1);
  endtask

  task automatic idle_in();
    upd_en = 0; blk_en = 0; wake_en = 0;
    upd_ctx = '0; blk_ctx = '0; wake_ctx = '0;
    upd_pc = '0; wake_pc = '0; blk_host = 0; wake_host = 0;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    idle_in();
  endtask

  task automatic park(int c, bit host);
    blk_en = 1; blk_ctx = W'(c); blk_host = host;
  endtask

  task automatic wake(int c, bit host, logic [31:0] pc);
    wake_en = 1; wake_ctx = W'(c); wake_host = host; wake_pc = pc;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_in();
    iss_ready = 1;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    compare("R1");
    chk("R1", "first ctx", 64'(iss_ctx), 64'd0);
    chk("R1", "first pc", 64'(iss_pc), 64'(RST_PC));
    rst_n = 1;
    step("R1");
    step("R1");

    // R2: rotation skips parked contexts and wraps
    park(1, 0); step("R2");
    park(2, 0); step("R2");
    park(5, 0); step("R2");
    for (int k = 0; k < 24; k++) step("R2");

    // R4: nothing ready drops the offer
    for (int c = 0; c < N; c++) begin park(c, 0); step("R6"); end
    step("R4");
    chk("R4", "valid low when empty", 64'(iss_valid), 64'd0);
    // R3: a single ready context issues back to back
    wake(7, 0, '0); step("R7");
    for (int k = 0; k < 4; k++) step("R3");
    chk("R3", "sole ctx", 64'(iss_ctx), 64'd7);
    wake(2, 0, '0); step("R7");
    wake(12, 0, '0); step("R7");
    // R4: hold offer while the pipeline refuses it
    iss_ready = 0;
    for (int k = 0; k < 3; k++) step("R4");
    iss_ready = 1;
    for (int k = 0; k < 4; k++) step("R4");

    // R5: next-PC write shows on the following offer
    for (int c = 0; c < N; c++) begin wake(c, 0, '0); step("R7"); end
    upd_en = 1; upd_ctx = 4'd3; upd_pc = 32'hAB00_0003; step("R5");
    upd_en = 1; upd_ctx = 4'd9; upd_pc = 32'hAB00_0009; step("R5");
    for (int k = 0; k < 16; k++) step("R5");

    // R6/R7/R8: host parking and its release rules
    park(3, 1); step("R6");
    chk("R6", "host flag 3", 64'(host_mask[3]), 64'd1);
    wake(3, 0, '0); step("R7");
    chk("R7", "miss wake ignored", 64'(rdy_mask[3]), 64'd0);
    park(3, 0); step("R6");
    chk("R6", "miss park keeps flag", 64'(host_mask[3]), 64'd1);
    wake(4, 1, 32'hDEAD_0004); step("R8");
    wake(3, 1, 32'hC0DE_0003); step("R8");
    chk("R8", "host return ready", 64'(rdy_mask[3]), 64'd1);
    for (int k = 0; k < 16; k++) step("R8");

    // R9: block and wake on one context in one cycle
    park(6, 0); wake(6, 0, '0); step("R9");
    chk("R9", "wake wins", 64'(rdy_mask[6]), 64'd1);
    park(8, 1); step("R9");
    park(8, 1); wake(8, 1, 32'h0000_8888); step("R9");
    chk("R9", "host wake wins", 64'(host_mask[8]), 64'd0);

    // R10: host PC beats pipeline update on the same context
    park(10, 1); step("R10");
    wake(10, 1, 32'h1010_1010); upd_en = 1; upd_ctx = 4'd10; upd_pc = 32'hBAD0_0010; step("R10");
    park(11, 1); step("R10");
    wake(11, 1, 32'h1111_0000); upd_en = 1; upd_ctx = 4'd12; upd_pc = 32'h1212_0000; step("R10");
    for (int k = 0; k < 16; k++) step("R10");

    // Mixed pseudo-random traffic against the model
    for (int k = 0; k < 3000; k++) begin
      iss_ready = ($urandom_range(9) != 0);
      if ($urandom_range(2) == 0) park($urandom_range(N-1), $urandom_range(3) == 0);
      if ($urandom_range(1) == 0) wake($urandom_range(N-1), $urandom_range(1) == 0, $urandom);
      if ($urandom_range(2) == 0) begin upd_en = 1; upd_ctx = W'($urandom_range(N-1)); upd_pc = $urandom; end
      step("R2");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule